// File: doc/BRIEF.md
# Hash Data Size Accumulator

This block stands between an input FIFO and a message-digest hashing core. It keeps a signed running total of the message bits that still have to be hashed. Each data-size write is added to the total rather than loaded into it. The block lets FIFO words through to the core only while the total is above zero and no error is pending. Each word the core accepts removes 64 bits from the total. When fewer than 64 bits remain, that last word is marked partial and the total drops to zero.

A negative total holds data back. Software can subtract first and add the remainder later, once the pad length is known. Writes are checked before they are applied:

- The size must be a whole number of bytes.
- In continue mode the size must also be a whole number of 512-bit blocks.
- The key size must not exceed 64 bytes.

A write that breaks a rule is discarded and sets a sticky error flag. The flag stays set until the clear input is pulsed. The block also decodes the three mode inputs into a pass kind, so that a multi-pass keyed-hash sequence (first, middle, final) can be recognised.

A state machine tracks the gate. Its states are:

- IDLE: the total is zero.
- RUN: the total is positive and words are released.
- HOLD: the total is negative.
- DONE: a one-cycle state, entered when a consumed word brings a positive total to zero.
- ERR: any error flag is set.

The next state is chosen from the next values of the total and the error flags, with ERR taking priority. The named transitions are:

- IDLE/HOLD→RUN: a write makes the total positive.
- RUN→DONE: the last word is consumed.
- DONE→IDLE: the cycle after DONE.
- any→HOLD: the total becomes negative.
- any→ERR: an error flag becomes set.
- ERR→(IDLE|RUN|HOLD): the flags are cleared.

Top module: `hash_size_gate`

## Requirements
- R1: After reset the size count, the key size and both error flags read 0. A reinit pulse clears the count and the key size but leaves the error flags unchanged.
- R2: An accepted size write adds its value, as a 21-bit two's-complement number, to the count. Successive writes accumulate.
- R3: While the count is positive and no error flag is set, core_valid equals fifo_valid, and fifo_pop equals core_valid AND core_ready.
- R4: While the count is zero or negative, core_valid and fifo_pop stay 0 whatever fifo_valid is.
- R5: Each popped word lowers the count by 64. If the count is below 64 while a word is offered, word_partial is 1, and popping that word sets the count to 0. Count bits [2:0] always read 0.
- R6: A size write whose bits [2:0] are not all zero sets err_size and leaves the count unchanged.
- R7: With mode_cont=1, a size write whose bits [8:0] are not all zero sets err_size and leaves the count unchanged.
- R8: A key write above 64 sets err_key and leaves key_size unchanged. A key write of 64 or less is stored and reads back on key_size.
- R9: The error flags stay set until an err_clr pulse. While either flag is set, core_valid is 0.
- R10: done is 1 for exactly the one cycle after a pop brings a positive count to 0.
- R11: pass_kind reads 1 for init=1,cont=1,hmac=1 (first), 2 for init=0,cont=1,hmac=0 (middle), 3 for init=0,cont=0,hmac=1 (final), and 0 for every other combination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reinit | input | 1 | Engine re-initialisation; clears count and key size |
| err_clr | input | 1 | Clears both sticky error flags |
| mode_init | input | 1 | Init mode bit |
| mode_cont | input | 1 | Continue mode bit; enables the 512-bit alignment rule |
| mode_hmac | input | 1 | Keyed-hash mode bit |
| size_wr | input | 1 | Data-size write strobe |
| size_wdata | input | 21 | Signed size value in bits, added to the count |
| key_wr | input | 1 | Key-size write strobe |
| key_wdata | input | 8 | Key size in bytes |
| fifo_valid | input | 1 | Input FIFO has a word |
| core_ready | input | 1 | Hash core accepts a word |
| core_valid | output | 1 | Word offered to the core |
| fifo_pop | output | 1 | Word transferred; pops the FIFO |
| word_partial | output | 1 | Offered word carries fewer than 64 valid bits |
| done | output | 1 | One-cycle pulse when the count is used up |
| size_count | output | 21 | Current signed count |
| key_size | output | 8 | Stored key size |
| err_size | output | 1 | Sticky data-size error |
| err_key | output | 1 | Sticky key-size error |
| pass_kind | output | 2 | Decoded pass kind |

## Verification
The hardest case to reach is the final short word. The count must be positive, not a multiple of 64, and then walked down by consumed words until under 64 bits remain. The bench writes 104, holds core_ready low to observe a full word offered, then pops twice: the second pop must be flagged partial and must bring on the DONE pulse. The held-back case needs a negative total followed by a positive write that crosses zero, and the bench drives that sequence with fifo_valid high throughout.

// File: rtl/hsg_pkg.sv
package hsg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_HOLD,
        ST_DONE,
        ST_ERR
    } gate_state_t;

    typedef enum logic [1:0] {
        PASS_OTHER  = 2'd0,
        PASS_FIRST  = 2'd1,
        PASS_MIDDLE = 2'd2,
        PASS_FINAL  = 2'd3
    } pass_kind_t;

    localparam int ERR_SIZE = 0;
    localparam int ERR_KEY  = 1;
    localparam int NUM_ERR  = 2;

    function automatic pass_kind_t decode_pass(input logic init, input logic cont,
                                               input logic hmac);
        pass_kind_t k;
        unique case ({init, cont, hmac})
            3'b111:  k = PASS_FIRST;
            3'b010:  k = PASS_MIDDLE;
            3'b001:  k = PASS_FINAL;
            default: k = PASS_OTHER;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/hsg_wr_check.sv
module hsg_wr_check #(
    parameter int CNT_W      = 21,
    parameter int KEY_W      = 8,
    parameter int KEY_MAX    = 64,
    parameter int UNIT_BITS  = 8,
    parameter int BLOCK_BITS = 512
) (
    input  logic             size_wr,
    input  logic [CNT_W-1:0] size_wdata,
    input  logic             mode_cont,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_wdata,
    output logic             size_add,
    output logic             size_bad,
    output logic             key_load,
    output logic             key_bad
);
    localparam int OFS_W = $clog2(UNIT_BITS);
    localparam int BLK_W = $clog2(BLOCK_BITS);
    localparam logic [KEY_W-1:0] KEY_LIMIT = KEY_W'(KEY_MAX);

    logic unit_miss;
    logic block_miss;

    always_comb begin
        unit_miss  = |size_wdata[OFS_W-1:0];
        block_miss = mode_cont & (|size_wdata[BLK_W-1:0]);
        size_bad   = size_wr & (unit_miss | block_miss);
        size_add   = size_wr & ~(unit_miss | block_miss);
        key_bad    = key_wr & (key_wdata > KEY_LIMIT);
        key_load   = key_wr & (key_wdata <= KEY_LIMIT);
    end

endmodule

// File: rtl/hsg_counter.sv
module hsg_counter #(
    parameter int CNT_W     = 21,
    parameter int WORD_BITS = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reinit,
    input  logic                    add_en,
    input  logic signed [CNT_W-1:0] add_val,
    input  logic                    consume,
    output logic signed [CNT_W-1:0] count_q,
    output logic signed [CNT_W-1:0] count_next,
    output logic                    short_word
);
    localparam logic signed [CNT_W-1:0] WORD_S = CNT_W'(WORD_BITS);

    logic signed [CNT_W-1:0] after_pop;
    logic signed [CNT_W-1:0] addend;

    always_comb begin
        if (!consume) begin
            after_pop = count_q;
        end else if (count_q <= WORD_S) begin
            after_pop = '0;
        end else begin
            after_pop = count_q - WORD_S;
        end
        addend     = add_en ? add_val : '0;
        count_next = reinit ? '0 : (after_pop + addend);
        short_word = (count_q < WORD_S);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_next;
        end
    end

endmodule

// File: rtl/hsg_err_flags.sv
module hsg_err_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [N-1:0] set,
    output logic [N-1:0] flags_q,
    output logic [N-1:0] flags_next
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_comb begin
            if (set[i]) begin
                flags_next[i] = 1'b1;
            end else if (clr) begin
                flags_next[i] = 1'b0;
            end else begin
                flags_next[i] = flags_q[i];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags_q[i] <= 1'b0;
            end else begin
                flags_q[i] <= flags_next[i];
            end
        end
    end

endmodule

// File: rtl/hsg_fsm.sv
module hsg_fsm
    import hsg_pkg::*;
#(
    parameter int CNT_W = 21
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [CNT_W-1:0] count_next,
    input  logic                    err_next,
    input  logic                    consume,
    input  logic                    reinit,
    output gate_state_t             state_q,
    output logic                    release_en,
    output logic                    done
);
    gate_state_t state_d;
    gate_state_t settle;

    always_comb begin
        if (err_next) begin
            settle = ST_ERR;
        end else if (count_next > 0) begin
            settle = ST_RUN;
        end else if (count_next < 0) begin
            settle = ST_HOLD;
        end else begin
            settle = ST_IDLE;
        end

        unique case (state_q)
            ST_RUN: begin
                if (settle == ST_IDLE && consume && !reinit) begin
                    state_d = ST_DONE;
                end else begin
                    state_d = settle;
                end
            end
            ST_IDLE, ST_HOLD, ST_DONE, ST_ERR: begin
                state_d = settle;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        release_en = 1'b0;
        done       = 1'b0;
        unique case (state_q)
            ST_RUN:  release_en = 1'b1;
            ST_DONE: done       = 1'b1;
            ST_IDLE, ST_HOLD, ST_ERR: begin
                release_en = 1'b0;
            end
            default: begin
                release_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/hash_size_gate.sv
module hash_size_gate
    import hsg_pkg::*;
#(
    parameter int CNT_W      = 21,
    parameter int KEY_W      = 8,
    parameter int KEY_MAX    = 64,
    parameter int WORD_BITS  = 64,
    parameter int UNIT_BITS  = 8,
    parameter int BLOCK_BITS = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reinit,
    input  logic             err_clr,
    input  logic             mode_init,
    input  logic             mode_cont,
    input  logic             mode_hmac,
    input  logic             size_wr,
    input  logic [CNT_W-1:0] size_wdata,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_wdata,
    input  logic             fifo_valid,
    input  logic             core_ready,
    output logic             core_valid,
    output logic             fifo_pop,
    output logic             word_partial,
    output logic             done,
    output logic [CNT_W-1:0] size_count,
    output logic [KEY_W-1:0] key_size,
    output logic             err_size,
    output logic             err_key,
    output logic [1:0]       pass_kind
);
    logic                    size_add;
    logic                    size_bad;
    logic                    key_load;
    logic                    key_bad;
    logic signed [CNT_W-1:0] count_q;
    logic signed [CNT_W-1:0] count_next;
    logic                    short_word;
    logic [NUM_ERR-1:0]      err_set;
    logic [NUM_ERR-1:0]      err_q;
    logic [NUM_ERR-1:0]      err_d;
    gate_state_t             state_q;
    logic                    release_en;
    logic [KEY_W-1:0]        key_q;

    hsg_wr_check #(
        .CNT_W(CNT_W), .KEY_W(KEY_W), .KEY_MAX(KEY_MAX),
        .UNIT_BITS(UNIT_BITS), .BLOCK_BITS(BLOCK_BITS)
    ) u_wr_check (
        .size_wr(size_wr), .size_wdata(size_wdata), .mode_cont(mode_cont),
        .key_wr(key_wr), .key_wdata(key_wdata),
        .size_add(size_add), .size_bad(size_bad),
        .key_load(key_load), .key_bad(key_bad)
    );

    hsg_counter #(.CNT_W(CNT_W), .WORD_BITS(WORD_BITS)) u_counter (
        .clk(clk), .rst_n(rst_n), .reinit(reinit),
        .add_en(size_add), .add_val($signed(size_wdata)),
        .consume(fifo_pop),
        .count_q(count_q), .count_next(count_next), .short_word(short_word)
    );

    always_comb begin
        err_set           = '0;
        err_set[ERR_SIZE] = size_bad;
        err_set[ERR_KEY]  = key_bad;
    end

    hsg_err_flags #(.N(NUM_ERR)) u_err (
        .clk(clk), .rst_n(rst_n), .clr(err_clr), .set(err_set),
        .flags_q(err_q), .flags_next(err_d)
    );

    hsg_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .count_next(count_next),
        .err_next(|err_d), .consume(fifo_pop), .reinit(reinit),
        .state_q(state_q), .release_en(release_en), .done(done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q <= '0;
        end else if (reinit) begin
            key_q <= '0;
        end else if (key_load) begin
            key_q <= key_wdata;
        end
    end

    always_comb begin
        core_valid   = release_en & fifo_valid;
        fifo_pop     = core_valid & core_ready;
        word_partial = core_valid & short_word;
        size_count   = count_q;
        key_size     = key_q;
        err_size     = err_q[ERR_SIZE];
        err_key      = err_q[ERR_KEY];
        pass_kind    = decode_pass(mode_init, mode_cont, mode_hmac);
    end

endmodule

// File: rtl/hsg_checker.sv
module hsg_checker #(
    parameter int CNT_W   = 21,
    parameter int KEY_W   = 8,
    parameter int KEY_MAX = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reinit,
    input logic             size_wr,
    input logic [CNT_W-1:0] size_wdata,
    input logic             core_valid,
    input logic             fifo_pop,
    input logic             done,
    input logic [CNT_W-1:0] size_count,
    input logic [KEY_W-1:0] key_size,
    input logic             err_size,
    input logic             err_key
);
    // R4
    nonpos_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(size_count) <= 0) |-> !core_valid);

    // R9
    err_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_size || err_key) |-> !core_valid);

    // R5
    word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_pop && $signed(size_count) > 64 && !size_wr && !reinit)
        |=> ($signed(size_count) == $past($signed(size_count)) - 64));

    // R5
    low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        size_count[2:0] == 3'b000);

    // R6
    offset_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (size_wr && size_wdata[2:0] != 3'b000) |=> err_size);

    // R8
    key_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_size <= KEY_W'(KEY_MAX));

    // R10
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(fifo_pop));

endmodule

bind hash_size_gate hsg_checker #(.CNT_W(CNT_W), .KEY_W(KEY_W), .KEY_MAX(KEY_MAX)) u_hsg_chk (
    .clk(clk), .rst_n(rst_n), .reinit(reinit), .size_wr(size_wr),
    .size_wdata(size_wdata), .core_valid(core_valid), .fifo_pop(fifo_pop),
    .done(done), .size_count(size_count), .key_size(key_size),
    .err_size(err_size), .err_key(err_key)
);

// File: tb/hash_size_gate_bench.sv
`timescale 1ns/1ps
module hash_size_gate_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reinit = 1'b0;
    logic        err_clr = 1'b0;
    logic        mode_init = 1'b0;
    logic        mode_cont = 1'b0;
    logic        mode_hmac = 1'b0;
    logic        size_wr = 1'b0;
    logic [20:0] size_wdata = '0;
    logic        key_wr = 1'b0;
    logic [7:0]  key_wdata = '0;
    logic        fifo_valid = 1'b0;
    logic        core_ready = 1'b0;
    logic        core_valid;
    logic        fifo_pop;
    logic        word_partial;
    logic        done;
    logic [20:0] size_count;
    logic [7:0]  key_size;
    logic        err_size;
    logic        err_key;
    logic [1:0]  pass_kind;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    hash_size_gate u_hash_size_gate (
        .clk(clk), .rst_n(rst_n), .reinit(reinit), .err_clr(err_clr),
        .mode_init(mode_init), .mode_cont(mode_cont), .mode_hmac(mode_hmac),
        .size_wr(size_wr), .size_wdata(size_wdata),
        .key_wr(key_wr), .key_wdata(key_wdata),
        .fifo_valid(fifo_valid), .core_ready(core_ready),
        .core_valid(core_valid), .fifo_pop(fifo_pop),
        .word_partial(word_partial), .done(done),
        .size_count(size_count), .key_size(key_size),
        .err_size(err_size), .err_key(err_key), .pass_kind(pass_kind)
    );

    function automatic int cnt();
        return int'($signed(size_count));
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr_size(input int v);
        size_wr    = 1'b1;
        size_wdata = v[20:0];
        @(negedge clk);
        size_wr    = 1'b0;
    endtask

    task automatic wr_key(input int v);
        key_wr    = 1'b1;
        key_wdata = v[7:0];
        @(negedge clk);
        key_wr    = 1'b0;
    endtask

    task automatic pulse_reinit();
        reinit = 1'b1;
        @(negedge clk);
        reinit = 1'b0;
    endtask

    task automatic pulse_clr();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        fifo_valid = 1'b1;
        @(negedge clk);
        check("R1", "count after reset", cnt(), 0);
        check("R1", "key after reset", int'(key_size), 0);
        check("R1", "errors after reset", int'({err_size, err_key}), 0);
        check("R4", "no release at zero", int'(core_valid), 0);
        fifo_valid = 1'b0;
    endtask

    task automatic t_full_words();
        wr_size(128);
        wr_size(128);
        check("R2", "accumulated writes", cnt(), 256);
        fifo_valid = 1'b1;
        #1;
        check("R3", "valid follows fifo", int'(core_valid), 1);
        check("R3", "no pop without ready", int'(fifo_pop), 0);
        core_ready = 1'b1;
        #1;
        check("R3", "pop with ready", int'(fifo_pop), 1);
        for (int i = 1; i <= 3; i++) begin
            @(negedge clk);
            check("R5", "count after pop", cnt(), 256 - 64 * i);
        end
        @(negedge clk);
        check("R5", "count at end", cnt(), 0);
        check("R10", "done pulse", int'(done), 1);
        check("R4", "no release in done", int'(core_valid), 0);
        @(negedge clk);
        check("R10", "done one cycle", int'(done), 0);
        fifo_valid = 1'b0;
        core_ready = 1'b0;
    endtask

    task automatic t_partial();
        wr_size(104);
        fifo_valid = 1'b1;
        #1;
        check("R5", "first word full", int'(word_partial), 0);
        core_ready = 1'b1;
        @(negedge clk);
        check("R5", "count 40", cnt(), 40);
        check("R5", "short word flagged", int'(word_partial), 1);
        @(negedge clk);
        check("R5", "short word empties", cnt(), 0);
        check("R10", "done after short", int'(done), 1);
        fifo_valid = 1'b0;
        core_ready = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_hold();
        fifo_valid = 1'b1;
        core_ready = 1'b0;
        wr_size(-128);
        check("R2", "negative count", cnt(), -128);
        check("R4", "held back", int'(core_valid), 0);
        wr_size(256);
        check("R2", "crossed zero", cnt(), 128);
        check("R3", "released after cross", int'(core_valid), 1);
        pulse_reinit();
        check("R1", "reinit clears count", cnt(), 0);
        fifo_valid = 1'b0;
    endtask

    task automatic t_size_errors();
        wr_size(128);
        wr_size(13);
        check("R6", "offset error flag", int'(err_size), 1);
        check("R6", "bad write discarded", cnt(), 128);
        fifo_valid = 1'b1;
        #1;
        check("R9", "error blocks release", int'(core_valid), 0);
        @(negedge clk);
        check("R9", "error sticky", int'(err_size), 1);
        pulse_clr();
        check("R9", "error cleared", int'(err_size), 0);
        check("R3", "release after clear", int'(core_valid), 1);
        fifo_valid = 1'b0;
        mode_cont = 1'b1;
        wr_size(256);
        check("R7", "block error flag", int'(err_size), 1);
        check("R7", "unaligned discarded", cnt(), 128);
        pulse_clr();
        wr_size(1024);
        check("R7", "aligned accepted", cnt(), 1152);
        check("R7", "no error aligned", int'(err_size), 0);
        mode_cont = 1'b0;
        pulse_reinit();
    endtask

    task automatic t_key();
        wr_key(64);
        check("R8", "key 64 stored", int'(key_size), 64);
        check("R8", "no key error", int'(err_key), 0);
        wr_key(65);
        check("R8", "key error flag", int'(err_key), 1);
        check("R8", "key unchanged", int'(key_size), 64);
        pulse_reinit();
        check("R1", "reinit clears key", int'(key_size), 0);
        check("R1", "reinit keeps error", int'(err_key), 1);
        pulse_clr();
        check("R9", "key error cleared", int'(err_key), 0);
    endtask

    task automatic t_pass();
        {mode_init, mode_cont, mode_hmac} = 3'b111;
        #1 check("R11", "first pass", int'(pass_kind), 1);
        {mode_init, mode_cont, mode_hmac} = 3'b010;
        #1 check("R11", "middle pass", int'(pass_kind), 2);
        {mode_init, mode_cont, mode_hmac} = 3'b001;
        #1 check("R11", "final pass", int'(pass_kind), 3);
        {mode_init, mode_cont, mode_hmac} = 3'b100;
        #1 check("R11", "other pass", int'(pass_kind), 0);
        {mode_init, mode_cont, mode_hmac} = 3'b000;
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_full_words();
        t_partial();
        t_hold();
        t_size_errors();
        t_key();
        t_pass();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule